// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the software-visible register file of a sixteen-channel DMA engine. A simple 32-bit bus (byte address, write enable, write data, combinational read data) reaches one bank of five registers per channel: buffer base address, line length, line count, control word and line stride. It also reaches a set of shared registers: a channel invalidate strobe register, a sticky interrupt status register, an interrupt enable register and a loop control register. The enable and loop registers each have a second address where writing ones clears bits.

Channel event inputs are collected into sticky status bits. These bits, gated by the enables, drive one level interrupt. A write to a channel's base address register launches that channel through a one-cycle start strobe. The control word's burst and direction bits, and each channel's loop pair, are decoded onto per-channel outputs for the address sequencers.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads as zero, irq is low, and no strobe or decoded output is high.
- R2: Channel n has base, line-length, line-count and control registers at byte addresses n*0x10 + 0x0, 0x4, 0x8 and 0xC. Each holds and returns all 32 bits written, and a write touches only its own register.
- R3: Channel n's stride register at 0x100 + 4*n holds and returns all 32 bits written.
- R4: A write to channel n's base register drives ch_start bit n high for exactly the one cycle after the write edge. Writes to the channel's other registers raise no start.
- R5: Writing to 0x140 drives ch_stop high for one cycle on every channel whose data bit is 1.
- R6: Status at 0x144 sets bit n when ch_event[n] is high. A bit stays set until a 1 is written to it. An event that arrives in the same cycle as a clear of the same bit leaves the bit set.
- R7: Interrupt enable at 0x148 is read/write. Writing ones to 0x14C clears exactly those enable bits and leaves the others unchanged.
- R8: Loop control at 0x150 is a 32-bit read/write register. Writing ones to 0x15C clears those bits. ch_loop_en[n] is high only when both bit n and bit n+16 are set.
- R9: irq is high exactly when some channel has both its status bit and its enable bit set. It follows an event or an enable write by one clock.
- R10: ch_burst[n] mirrors bit 4 of channel n's control register, and ch_dir[n] mirrors bit 5.
- R11: Reads of 0x14C and 0x15C return the enable and loop registers. Reads of 0x140, of unmapped addresses and of addresses that are not word aligned return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write enable, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ch_event | input | 16 | Per-channel completion events |
| ch_start | output | 16 | One-cycle start strobes |
| ch_stop | output | 16 | One-cycle invalidate strobes |
| ch_burst | output | 16 | Decoded burst mode per channel |
| ch_dir | output | 16 | Decoded transfer direction per channel |
| ch_loop_en | output | 16 | Loop mode per channel |
| irq | output | 1 | Combined interrupt |

## Verification
A faulty decode shows up at the next read as a value that lands in the wrong channel or the wrong register. A missing or extra strobe is visible on ch_start or ch_stop in the very cycle after the write. A bad merge of events and clears in the status register, or a slip in the alias clear, shows as a wrong value on the next status or enable read, and irq goes wrong one clock after the faulty update. The bench therefore reads back after every write, and it probes strobes in the cycle after the write and again in the cycle after that.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

  localparam int DW          = 32;
  localparam int STRIDE_BASE = 32'h100;
  localparam int VALID_A     = 32'h140;
  localparam int STAT_A      = 32'h144;
  localparam int IEN_A       = 32'h148;
  localparam int IEN_CLR_A   = 32'h14C;
  localparam int LOOP_A      = 32'h150;
  localparam int LOOP_CLR_A  = 32'h15C;

  // control word bits decoded by the sequencers
  localparam int CTRL_BURST_BIT = 4;
  localparam int CTRL_DIR_BIT   = 5;
  // second loop bit of a channel sits this far above the first
  localparam int LOOP_PAIR      = 16;

  typedef enum logic [1:0] {
    F_BASE  = 2'd0,
    F_LLEN  = 2'd1,
    F_LCNT  = 2'd2,
    F_CTRL  = 2'd3
  } field_e;

  typedef enum logic [3:0] {
    K_NONE, K_CHAN, K_STRIDE, K_VALID, K_STAT,
    K_IEN, K_IEN_CLR, K_LOOP, K_LOOP_CLR
  } kind_e;

  typedef struct packed {
    logic [DW-1:0] base;
    logic [DW-1:0] line_len;
    logic [DW-1:0] line_cnt;
    logic [DW-1:0] ctrl;
    logic [DW-1:0] stride;
  } chan_regs_t;

endpackage

// File: rtl/dma_rf_rstsync.sv
module dma_rf_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic [CH_W-1:0]   ch,
  output field_e            field
);
  localparam int CHAN_SPAN  = NUM_CH * 16;
  localparam int STRIDE_END = STRIDE_BASE + 4 * NUM_CH;

  logic [31:0] a_ext;
  assign a_ext = {{(32-ADDR_W){1'b0}}, addr};

  always_comb begin
    kind  = K_NONE;
    ch    = '0;
    field = field_e'(addr[3:2]);
    if (addr[1:0] != 2'b00) begin
      kind = K_NONE;
    end else if (a_ext < CHAN_SPAN) begin
      kind = K_CHAN;
      ch   = addr[CH_W+3:4];
    end else if (a_ext >= STRIDE_BASE && a_ext < STRIDE_END) begin
      kind = K_STRIDE;
      ch   = addr[CH_W+1:2];
    end else begin
      case (a_ext)
        VALID_A:    kind = K_VALID;
        STAT_A:     kind = K_STAT;
        IEN_A:      kind = K_IEN;
        IEN_CLR_A:  kind = K_IEN_CLR;
        LOOP_A:     kind = K_LOOP;
        LOOP_CLR_A: kind = K_LOOP_CLR;
        default:    kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_chan,
  input  logic          wr_stride,
  input  field_e        field,
  input  logic [DW-1:0] wdata,
  output chan_regs_t    regs_q,
  output logic          start_q
);
  chan_regs_t regs_d;
  logic       regs_en;
  logic       start_d;

  always_comb begin
    regs_d  = regs_q;
    regs_en = wr_chan | wr_stride;
    if (wr_stride) regs_d.stride = wdata;
    if (wr_chan) begin
      case (field)
        F_BASE:  regs_d.base     = wdata;
        F_LLEN:  regs_d.line_len = wdata;
        F_LCNT:  regs_d.line_cnt = wdata;
        default: regs_d.ctrl     = wdata;
      endcase
    end
    start_d = wr_chan && (field == F_BASE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (regs_en) regs_q <= regs_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/dma_rf_shared.sv
module dma_rf_shared
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  kind_e             kind,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] ch_event,
  output logic [NUM_CH-1:0] stat_q,
  output logic [NUM_CH-1:0] ien_q,
  output logic [DW-1:0]     loop_q,
  output logic [NUM_CH-1:0] stop_q,
  output logic              irq
);
  logic [NUM_CH-1:0] wlo;
  logic [NUM_CH-1:0] stat_d, ien_d, stop_d, stat_clr;
  logic [DW-1:0]     loop_d;
  logic              stat_en, ien_en, loop_en;

  assign wlo = wdata[NUM_CH-1:0];

  always_comb begin
    stat_clr = (wr_en && kind == K_STAT) ? wlo : '0;
    // events are merged after the clear so a coincident event survives
    stat_d   = (stat_q & ~stat_clr) | ch_event;
    stat_en  = (wr_en && kind == K_STAT) || (|ch_event);

    ien_d  = ien_q;
    ien_en = 1'b0;
    if (wr_en && kind == K_IEN)     begin ien_d = wlo;           ien_en = 1'b1; end
    if (wr_en && kind == K_IEN_CLR) begin ien_d = ien_q & ~wlo;  ien_en = 1'b1; end

    loop_d  = loop_q;
    loop_en = 1'b0;
    if (wr_en && kind == K_LOOP)     begin loop_d = wdata;           loop_en = 1'b1; end
    if (wr_en && kind == K_LOOP_CLR) begin loop_d = loop_q & ~wdata; loop_en = 1'b1; end

    stop_d = (wr_en && kind == K_VALID) ? wlo : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ien_q  <= '0;
      loop_q <= '0;
      stop_q <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (ien_en)  ien_q  <= ien_d;
      if (loop_en) loop_q <= loop_d;
      stop_q <= stop_d;
    end
  end

  assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NUM_CH-1:0] ch_event,
  output logic [NUM_CH-1:0] ch_start,
  output logic [NUM_CH-1:0] ch_stop,
  output logic [NUM_CH-1:0] ch_burst,
  output logic [NUM_CH-1:0] ch_dir,
  output logic [NUM_CH-1:0] ch_loop_en,
  output logic              irq
);
  logic              rst_sync_n;
  kind_e             dec_kind;
  logic [CH_W-1:0]   dec_ch;
  field_e            dec_field;
  chan_regs_t        regs [NUM_CH];
  logic [NUM_CH-1:0] stat_q, ien_q;
  logic [DW-1:0]     loop_q;

  dma_rf_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dma_rf_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr  (bus_addr),
    .kind  (dec_kind),
    .ch    (dec_ch),
    .field (dec_field)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic wr_c, wr_s;
    assign wr_c = bus_we && dec_kind == K_CHAN   && dec_ch == CH_W'(n);
    assign wr_s = bus_we && dec_kind == K_STRIDE && dec_ch == CH_W'(n);

    dma_rf_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .wr_chan   (wr_c),
      .wr_stride (wr_s),
      .field     (dec_field),
      .wdata     (bus_wdata),
      .regs_q    (regs[n]),
      .start_q   (ch_start[n])
    );

    assign ch_burst[n]   = regs[n].ctrl[CTRL_BURST_BIT];
    assign ch_dir[n]     = regs[n].ctrl[CTRL_DIR_BIT];
    assign ch_loop_en[n] = loop_q[n] & loop_q[n+LOOP_PAIR];
  end

  dma_rf_shared #(.NUM_CH(NUM_CH)) u_shared (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (bus_we),
    .kind     (dec_kind),
    .wdata    (bus_wdata),
    .ch_event (ch_event),
    .stat_q   (stat_q),
    .ien_q    (ien_q),
    .loop_q   (loop_q),
    .stop_q   (ch_stop),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (dec_kind)
      K_CHAN: begin
        case (dec_field)
          F_BASE:  bus_rdata = regs[dec_ch].base;
          F_LLEN:  bus_rdata = regs[dec_ch].line_len;
          F_LCNT:  bus_rdata = regs[dec_ch].line_cnt;
          default: bus_rdata = regs[dec_ch].ctrl;
        endcase
      end
      K_STRIDE:             bus_rdata = regs[dec_ch].stride;
      K_STAT:               bus_rdata = DW'(stat_q);
      K_IEN, K_IEN_CLR:     bus_rdata = DW'(ien_q);
      K_LOOP, K_LOOP_CLR:   bus_rdata = loop_q;
      default:              bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma_rf_checker.sv
module dma_rf_checker
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [NUM_CH-1:0] wdata_lo,
  input logic [NUM_CH-1:0] ch_event,
  input logic [NUM_CH-1:0] ch_start,
  input logic [NUM_CH-1:0] ch_stop,
  input logic [NUM_CH-1:0] ch_loop_en,
  input logic              irq,
  input logic [NUM_CH-1:0] stat_q,
  input logic [NUM_CH-1:0] ien_q
);
  localparam int CHAN_SPAN = NUM_CH * 16;

  logic base_wr, valid_wr, ien_wr, ien_clr_wr, loop_wr;
  assign base_wr    = bus_we && ({{(32-ADDR_W){1'b0}}, bus_addr} < CHAN_SPAN) && bus_addr[3:0] == 4'h0;
  assign valid_wr   = bus_we && bus_addr == ADDR_W'(VALID_A);
  assign ien_wr     = bus_we && bus_addr == ADDR_W'(IEN_A);
  assign ien_clr_wr = bus_we && bus_addr == ADDR_W'(IEN_CLR_A);
  assign loop_wr    = bus_we && bus_addr == ADDR_W'(LOOP_A);

  // R4: at most one start at a time, and only after a base write
  a_r4_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));
  a_r4_start_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |-> $past(base_wr));

  // R5: invalidate strobes follow a write to the invalidate address
  a_r5_stop_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_stop != '0) |-> $past(valid_wr));

  // R6: an event always leaves its status bit set
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_event != '0) |=> ((stat_q & $past(ch_event)) == $past(ch_event)));

  // R7: alias write clears the named enable bits
  a_r7_ien_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr_wr |=> ((ien_q & $past(wdata_lo)) == '0));

  // R8: a channel enters loop mode only through the main loop address
  a_r8_loop_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_loop_en & ~$past(ch_loop_en)) != '0) |-> $past(loop_wr));

  // R9: interrupt rises only after an event or an enable write
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ch_event != '0) || $past(ien_wr)));
endmodule

bind dma_regfile dma_rf_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .wdata_lo   (bus_wdata[NUM_CH-1:0]),
  .ch_event   (ch_event),
  .ch_start   (ch_start),
  .ch_stop    (ch_stop),
  .ch_loop_en (ch_loop_en),
  .irq        (irq),
  .stat_q     (stat_q),
  .ien_q      (ien_q)
);

// File: tb/dma_regfile_tb.sv
module dma_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ch_event;
  logic [15:0] ch_start, ch_stop, ch_burst, ch_dir, ch_loop_en;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_event(ch_event),
    .ch_start(ch_start), .ch_stop(ch_stop), .ch_burst(ch_burst),
    .ch_dir(ch_dir), .ch_loop_en(ch_loop_en), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // returns at the falling edge after the capturing edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic t_reset;
    rd_check("R1 base0", 12'h000, 0);
    rd_check("R1 ctrl15", 12'h0FC, 0);
    rd_check("R1 stride15", 12'h13C, 0);
    rd_check("R1 status", 12'h144, 0);
    rd_check("R1 ien", 12'h148, 0);
    rd_check("R1 loop", 12'h150, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 strobes", {ch_start, ch_stop}, 0);
    check("R1 decoded", {ch_burst, ch_loop_en}, 0);
  endtask

  task automatic t_chan_regs;
    wr(12'h004, 32'hA5A5_0001);
    wr(12'h008, 32'h0000_FFFF);
    wr(12'h0F4, 32'hDEAD_BEEF);
    wr(12'h0F8, 32'h1234_5678);
    wr(12'h054, 32'h0000_0055);
    rd_check("R2 ch0 line_len", 12'h004, 32'hA5A5_0001);
    rd_check("R2 ch0 line_cnt", 12'h008, 32'h0000_FFFF);
    rd_check("R2 ch15 line_len", 12'h0F4, 32'hDEAD_BEEF);
    rd_check("R2 ch15 line_cnt", 12'h0F8, 32'h1234_5678);
    rd_check("R2 ch5 line_len", 12'h054, 32'h0000_0055);
    rd_check("R2 ch6 untouched", 12'h064, 0);
    rd_check("R2 ch5 base untouched", 12'h050, 0);
  endtask

  task automatic t_stride;
    wr(12'h100, 32'h0000_0040);
    wr(12'h13C, 32'hFFFF_FFFF);
    rd_check("R3 stride ch0", 12'h100, 32'h0000_0040);
    rd_check("R3 stride ch15", 12'h13C, 32'hFFFF_FFFF);
    rd_check("R3 stride ch1 untouched", 12'h104, 0);
  endtask

  task automatic t_start;
    wr(12'h070, 32'h8000_0000);
    check("R4 start ch7", 32'(ch_start), 32'h0080);
    @(negedge clk);
    check("R4 start one cycle", 32'(ch_start), 0);
    rd_check("R2 ch7 base", 12'h070, 32'h8000_0000);
    wr(12'h074, 32'h0000_0010);
    check("R4 no start on line_len", 32'(ch_start), 0);
  endtask

  task automatic t_stop;
    wr(12'h140, 32'h0000_8001);
    check("R5 stop ch0 ch15", 32'(ch_stop), 32'h8001);
    @(negedge clk);
    check("R5 stop one cycle", 32'(ch_stop), 0);
    rd_check("R11 valid reads zero", 12'h140, 0);
  endtask

  task automatic t_status;
    @(negedge clk);
    ch_event = 16'h0012;
    @(negedge clk);
    ch_event = 16'h0000;
    rd_check("R6 status set", 12'h144, 32'h12);
    @(negedge clk);
    rd_check("R6 status sticky", 12'h144, 32'h12);
    wr(12'h144, 32'h0000_0002);
    rd_check("R6 w1c", 12'h144, 32'h10);
    @(negedge clk);
    bus_addr = 12'h144; bus_wdata = 32'h10; bus_we = 1'b1; ch_event = 16'h0010;
    @(negedge clk);
    bus_we = 1'b0; ch_event = 16'h0000;
    rd_check("R6 event beats clear", 12'h144, 32'h10);
    wr(12'h144, 32'h0000_0010);
    rd_check("R6 cleared", 12'h144, 0);
  endtask

  task automatic t_ien;
    wr(12'h148, 32'h0000_F0F0);
    rd_check("R7 ien write", 12'h148, 32'hF0F0);
    wr(12'h14C, 32'h0000_3030);
    rd_check("R7 ien alias clear", 12'h148, 32'hC0C0);
    rd_check("R11 ien alias read", 12'h14C, 32'hC0C0);
  endtask

  task automatic t_loop;
    wr(12'h150, 32'h0003_0001);
    check("R8 loop ch0 only", 32'(ch_loop_en), 32'h0001);
    rd_check("R8 loop read", 12'h150, 32'h0003_0001);
    wr(12'h15C, 32'h0001_0000);
    check("R8 loop cleared by alias", 32'(ch_loop_en), 0);
    rd_check("R11 loop alias read", 12'h15C, 32'h0002_0001);
  endtask

  task automatic t_irq;
    check("R9 irq idle", 32'(irq), 0);
    @(negedge clk);
    ch_event = 16'h0040;
    #1;
    check("R9 irq not before edge", 32'(irq), 0);
    @(negedge clk);
    ch_event = 16'h0000;
    check("R9 irq on enabled event", 32'(irq), 1);
    wr(12'h144, 32'h0000_0040);
    check("R9 irq drops after clear", 32'(irq), 0);
    @(negedge clk);
    ch_event = 16'h0001;
    @(negedge clk);
    ch_event = 16'h0000;
    check("R9 masked event no irq", 32'(irq), 0);
    wr(12'h148, 32'h0000_0001);
    check("R9 irq on enable", 32'(irq), 1);
    wr(12'h144, 32'h0000_0001);
    check("R9 irq cleared", 32'(irq), 0);
  endtask

  task automatic t_ctrl;
    wr(12'h03C, 32'h0000_0010);
    wr(12'h09C, 32'h0000_0020);
    check("R10 burst ch3", 32'(ch_burst), 32'h0008);
    check("R10 dir ch9", 32'(ch_dir), 32'h0200);
    rd_check("R2 ch3 ctrl", 12'h03C, 32'h10);
  endtask

  task automatic t_undef;
    rd_check("R11 unmapped 0x158", 12'h158, 0);
    rd_check("R11 unmapped 0x200", 12'h200, 0);
    rd_check("R11 misaligned", 12'h006, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; ch_event = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_chan_regs();
    t_stride();
    t_start();
    t_stop();
    t_status();
    t_ien();
    t_loop();
    t_irq();
    t_ctrl();
    t_undef();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule